// File: doc/BRIEF.md
# Indirect Data Address Channel Sequencer

This block produces the real storage byte addresses for one data-transfer command of an I/O channel. It is given a 64-bit command word and a byte count on a start pulse. It decodes the command code and the indirect flag, and then emits one byte address per transfer beat until the count runs out. It ends with a one-cycle done pulse, or with a one-cycle error pulse (program check) if the command or an address list entry is badly formed.

With the indirect flag clear, addresses run straight from the data address in the command word. With the flag set, that field instead points at a list of 4-byte address words, which the block reads through a request/grant memory port. The first list word gives any starting address. Each later word is fetched only when a 2 KB block edge is crossed, and it must name the first byte of a block. For read-backward it must name the last byte of a block.

Top module: `idx_chan_seq`

## Requirements
- R1: After reset, busy, mem_req, beat_valid, done and err are all low.
- R2: The command code is word bits [63:56]. Low two bits 01 = write, 10 = read, 11 = control. Low nibble 0100 = sense, 1100 = read-backward. Any other code gives an err pulse with no beat and no fetch.
- R3: With the indirect flag (word bit 26) clear, the first beat carries word bits [55:32]. Later beats step by +1 (by -1 for read-backward), modulo 2^24, through block edges with no fetch.
- R4: With the flag set, the first fetch reads the list address (word bits [55:32]) before any beat. mem_req and mem_addr hold until mem_gnt.
- R5: The first list word may hold any address, taken from its bits [23:0], and the first beat carries it.
- R6: When a beat with low 11 address bits all ones (forward) or all zeros (backward) is taken and bytes remain, the next list word is fetched at the previous list address plus 4.
- R7: A later list word whose low 11 bits are not all zeros (forward) or all ones (backward) gives an err pulse, and no further beats follow.
- R8: A list word with bits [31:24] nonzero gives an err pulse and ends the sequence.
- R9: A list address that is not a multiple of 4 gives an err pulse without any fetch.
- R10: Exactly byte_cnt beats are issued, then a done pulse. No fetch follows the last byte, even on a block edge. A zero count gives done with no beat and no fetch.
- R11: While beat_valid is high and beat_ready low, beat_valid and beat_addr hold.
- R12: A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a command (taken when idle) |
| cmd_word | input | 64 | Command word |
| byte_cnt | input | CNT_W | Number of bytes to address |
| busy | output | 1 | A command is in progress |
| mem_req | output | 1 | List word read request |
| mem_addr | output | 24 | List word address |
| mem_gnt | input | 1 | Read granted, data valid this cycle |
| mem_rdata | input | 32 | List word read data |
| beat_valid | output | 1 | Beat address valid |
| beat_addr | output | 24 | Real byte address of this beat |
| beat_ready | input | 1 | Beat accepted |
| done | output | 1 | One-cycle pulse: all bytes addressed |
| err | output | 1 | One-cycle pulse: program check |

## Verification
The bench keeps the block edge at 11 bits and narrows the count to 13 bits. This allows counts of several thousand bytes, so one command crosses two or three 2 KB edges in either direction. The sweep sets the first list word just beside an edge and uses counts that end exactly on an edge, one byte past it, and one full block further. This shows both that a fetch happens at each crossing and that no fetch follows a final byte on an edge. Stalls on the grant and ready inputs show that the handshakes hold their values.

// File: rtl/idx_seq_pkg.sv
package idx_seq_pkg;

    localparam int CMD_W    = 64;
    localparam int ENTRY_W  = 32;
    localparam int RADDR_W  = 24;
    localparam int CODE_W   = 8;
    // field positions, numbered from the most significant bit as 0
    localparam int FLAG_POS = 37;
    localparam int ADDR_POS = 8;
    localparam int STEP_B   = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_BEAT
    } seq_st_e;

    typedef enum logic [2:0] {
        K_BAD,
        K_WRITE,
        K_READ,
        K_CTRL,
        K_SENSE,
        K_RDBACK
    } cmd_kind_e;

endpackage

// File: rtl/idx_cmd_decode.sv
module idx_cmd_decode
    import idx_seq_pkg::*;
(
    input  logic [CMD_W-1:0]   word,
    output cmd_kind_e          kind,
    output logic               ok,
    output logic               bwd,
    output logic               ind,
    output logic [RADDR_W-1:0] addr
);
    localparam int CODE_HI = CMD_W - 1;
    localparam int ADDR_HI = CMD_W - 1 - ADDR_POS;
    localparam int FLAG_IX = CMD_W - 1 - FLAG_POS;

    logic [CODE_W-1:0] code;
    logic              spare_unused;

    assign code = word[CODE_HI -: CODE_W];
    assign addr = word[ADDR_HI -: RADDR_W];
    assign ind  = word[FLAG_IX];
    assign spare_unused = ^{word[ADDR_HI-RADDR_W:FLAG_IX+1], word[FLAG_IX-1:0]};

    always_comb begin
        kind = K_BAD;
        unique case (code[1:0])
            2'b01: kind = K_WRITE;
            2'b10: kind = K_READ;
            2'b11: kind = K_CTRL;
            default: begin
                if (code[3:0] == 4'b0100)      kind = K_SENSE;
                else if (code[3:0] == 4'b1100) kind = K_RDBACK;
                else                           kind = K_BAD;
            end
        endcase
    end

    assign ok  = (kind != K_BAD);
    assign bwd = (kind == K_RDBACK);

endmodule

// File: rtl/idx_entry_check.sv
module idx_entry_check
    import idx_seq_pkg::*;
#(
    parameter int BLK_W = 11
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic               first,
    input  logic               bwd,
    output logic               ok,
    output logic [RADDR_W-1:0] addr
);
    localparam int PAD_W = ENTRY_W - RADDR_W;

    logic pad_clear;
    logic edge_ok;

    assign addr      = entry[RADDR_W-1:0];
    assign pad_clear = (entry[ENTRY_W-1 -: PAD_W] == '0);

    generate
        if (BLK_W > 0) begin : g_edge
            assign edge_ok = bwd ? (&entry[BLK_W-1:0]) : (~|entry[BLK_W-1:0]);
        end else begin : g_noedge
            assign edge_ok = 1'b1;
        end
    endgenerate

    assign ok = pad_clear && (first || edge_ok);

endmodule

// File: rtl/idx_addr_step.sv
module idx_addr_step
    import idx_seq_pkg::*;
#(
    parameter int BLK_W = 11
) (
    input  logic [RADDR_W-1:0] cur,
    input  logic               bwd,
    output logic [RADDR_W-1:0] nxt,
    output logic               at_edge
);
    assign nxt     = bwd ? (cur - RADDR_W'(1)) : (cur + RADDR_W'(1));
    assign at_edge = bwd ? (~|cur[BLK_W-1:0]) : (&cur[BLK_W-1:0]);
endmodule

// File: rtl/idx_chan_seq.sv
module idx_chan_seq
    import idx_seq_pkg::*;
#(
    parameter int BLK_W = 11,
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [CMD_W-1:0]     cmd_word,
    input  logic [CNT_W-1:0]     byte_cnt,
    output logic                 busy,
    output logic                 mem_req,
    output logic [RADDR_W-1:0]   mem_addr,
    input  logic                 mem_gnt,
    input  logic [ENTRY_W-1:0]   mem_rdata,
    output logic                 beat_valid,
    output logic [RADDR_W-1:0]   beat_addr,
    input  logic                 beat_ready,
    output logic                 done,
    output logic                 err
);
    localparam int ADDR_W = RADDR_W;

    typedef struct packed {
        seq_st_e           st;
        logic [ADDR_W-1:0] cur;
        logic [ADDR_W-1:0] lptr;
        logic [CNT_W-1:0]  cnt;
        logic              bwd;
        logic              ind;
        logic              first;
        logic              done;
        logic              err;
    } seq_t;

    seq_t r_d, r_q;

    cmd_kind_e         dec_kind;
    logic              dec_ok, dec_bwd, dec_ind;
    logic [ADDR_W-1:0] dec_addr;
    logic              chk_ok;
    logic [ADDR_W-1:0] chk_addr;
    logic [ADDR_W-1:0] step_nxt;
    logic              step_edge;
    logic              kind_unused;

    idx_cmd_decode u_dec (
        .word (cmd_word),
        .kind (dec_kind),
        .ok   (dec_ok),
        .bwd  (dec_bwd),
        .ind  (dec_ind),
        .addr (dec_addr)
    );

    assign kind_unused = (dec_kind == K_SENSE);

    idx_entry_check #(.BLK_W(BLK_W)) u_chk (
        .entry (mem_rdata),
        .first (r_q.first),
        .bwd   (r_q.bwd),
        .ok    (chk_ok),
        .addr  (chk_addr)
    );

    idx_addr_step #(.BLK_W(BLK_W)) u_step (
        .cur     (r_q.cur),
        .bwd     (r_q.bwd),
        .nxt     (step_nxt),
        .at_edge (step_edge)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.bwd   = dec_bwd;
                    r_d.ind   = dec_ind;
                    r_d.cnt   = byte_cnt;
                    r_d.first = 1'b1;
                    if (!dec_ok) begin
                        r_d.err = 1'b1;
                    end else if (byte_cnt == '0) begin
                        r_d.done = 1'b1;
                    end else if (dec_ind) begin
                        if (dec_addr[1:0] != 2'b00) begin
                            r_d.err = 1'b1;
                        end else begin
                            r_d.lptr = dec_addr;
                            r_d.st   = ST_FETCH;
                        end
                    end else begin
                        r_d.cur = dec_addr;
                        r_d.st  = ST_BEAT;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_gnt) begin
                    if (!chk_ok) begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_IDLE;
                    end else begin
                        r_d.cur   = chk_addr;
                        r_d.first = 1'b0;
                        r_d.st    = ST_BEAT;
                    end
                end
            end
            ST_BEAT: begin
                if (beat_ready) begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                    if (r_q.cnt == CNT_W'(1)) begin
                        r_d.done = 1'b1;
                        r_d.st   = ST_IDLE;
                    end else if (r_q.ind && step_edge) begin
                        r_d.lptr = r_q.lptr + ADDR_W'(STEP_B);
                        r_d.st   = ST_FETCH;
                    end else begin
                        r_d.cur = step_nxt;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cur: '0, lptr: '0, cnt: '0, bwd: 1'b0,
                     ind: 1'b0, first: 1'b0, done: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.st != ST_IDLE);
    assign mem_req    = (r_q.st == ST_FETCH);
    assign mem_addr   = r_q.lptr;
    assign beat_valid = (r_q.st == ST_BEAT);
    assign beat_addr  = r_q.cur;
    assign done       = r_q.done;
    assign err        = r_q.err;

    // R11: an offered beat waits unchanged for acceptance
    p_beat_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr));

    // R4: a list read stays posted until granted
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));

    // R4: list reads and data beats never overlap
    p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && beat_valid));

    // R9: list reads are always word aligned
    p_list_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);

    // R3: direct forward beats step by one
    p_fwd_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_ready && r_q.cnt != CNT_W'(1) && !r_q.ind && !r_q.bwd
        |=> beat_valid && beat_addr == $past(beat_addr) + ADDR_W'(1));

    // R10: the last beat ends the run with done and nothing else
    p_last_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_ready && r_q.cnt == CNT_W'(1)
        |=> done && !mem_req && !beat_valid);

    // R8: a list word with a nonzero pad byte stops the run
    p_pad_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_gnt && mem_rdata[ENTRY_W-1:RADDR_W] != '0 |=> err && !busy);

    // R7: a forward follow-on word off a block start stops the run
    p_fwd_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_gnt && !r_q.first && !r_q.bwd && mem_rdata[BLK_W-1:0] != '0
        |=> err && !beat_valid);

    // R6: a forward beat at a block end fetches the next word
    p_next_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_ready && r_q.ind && !r_q.bwd && r_q.cnt != CNT_W'(1)
        && (&beat_addr[BLK_W-1:0])
        |=> mem_req && mem_addr == $past(mem_addr) + ADDR_W'(STEP_B));

    // R2: done and err never coincide
    p_one_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

endmodule

// File: tb/sim_idx_chan_seq.sv
module sim_idx_chan_seq;
    localparam int BLK   = 11;
    localparam int CNT_W = 13;
    localparam int BSZ   = 1 << BLK;
    localparam logic [23:0] LBASE = 24'h000200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] cmd_word = '0;
    logic [CNT_W-1:0] byte_cnt = '0;
    logic        busy, mem_req, mem_gnt, beat_valid, beat_ready, done, err;
    logic [23:0] mem_addr, beat_addr;
    logic [31:0] mem_rdata;

    int checks = 0;
    int fails  = 0;
    logic [31:0] lmem [0:7];

    always #10 clk = ~clk;

    idx_chan_seq #(.BLK_W(BLK), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_word(cmd_word),
        .byte_cnt(byte_cnt), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .beat_valid(beat_valid),
        .beat_addr(beat_addr), .beat_ready(beat_ready), .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_cmd(input logic [7:0] code, input bit ind,
                                           input logic [23:0] a);
        logic [63:0] w;
        w = {code, a, 32'h0};
        w[26] = ind;
        return w;
    endfunction

    task automatic setup_list(input logic [31:0] e0, input bit bwd);
        lmem[0] = e0;
        for (int i = 1; i < 8; i++)
            lmem[i] = 32'h0001_0000 + 32'(i * BSZ) + (bwd ? 32'(BSZ - 1) : 32'h0);
    endtask

    function automatic int first_run(input bit bwd, input logic [23:0] e0);
        int off;
        off = int'(e0) % BSZ;
        return bwd ? off + 1 : BSZ - off;
    endfunction

    function automatic int fetches_for(input bit bwd, input logic [23:0] e0, input int cnt);
        int n0;
        n0 = first_run(bwd, e0);
        return 1 + ((cnt > n0) ? (cnt - n0 + BSZ - 1) / BSZ : 0);
    endfunction

    function automatic logic [23:0] exp_addr(input bit ind, input bit bwd,
                                             input logic [23:0] a, input int k);
        int n0, j, r;
        logic [23:0] e0, e;
        if (!ind) return bwd ? a - 24'(k) : a + 24'(k);
        e0 = lmem[0][23:0];
        n0 = first_run(bwd, e0);
        if (k < n0) return bwd ? e0 - 24'(k) : e0 + 24'(k);
        j = (k - n0) / BSZ;
        r = (k - n0) % BSZ;
        e = (j + 1 < 8) ? lmem[j + 1][23:0] : 24'h0;
        return bwd ? e - 24'(r) : e + 24'(r);
    endfunction

    task automatic run_case(input string req, input logic [7:0] code, input bit ind,
                            input logic [23:0] a, input int cnt, input bit exp_err,
                            input int exp_beats, input int exp_fetch, input bit poke);
        int beats, fetches, cyc, idx;
        bit fin, got_err, got_done, bwd, rdy;
        beats = 0; fetches = 0; cyc = 0; fin = 0; got_err = 0; got_done = 0;
        bwd = (code[3:0] == 4'b1100);
        @(negedge clk);
        cmd_word = mk_cmd(code, ind, a);
        byte_cnt = CNT_W'(cnt);
        start    = 1'b1;
        while (!fin && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            start = 1'b0;
            if (poke && cyc == 3) begin
                cmd_word = mk_cmd(8'h0C, 1'b0, 24'hABCDEF);
                byte_cnt = CNT_W'(3);
                start    = 1'b1;
            end
            if (done || err) begin
                got_done = done; got_err = err; fin = 1;
                mem_gnt = 1'b0; beat_ready = 1'b0;
            end else begin
                if (mem_req && (cyc % 3 == 0)) begin
                    chk(mem_addr == a + 24'(4 * fetches), "R6",
                        "list address", mem_addr, a + 24'(4 * fetches));
                    idx = int'(mem_addr - LBASE) >> 2;
                    mem_rdata = (idx >= 0 && idx < 8) ? lmem[idx] : 32'h0;
                    mem_gnt = 1'b1;
                    fetches++;
                end else begin
                    mem_gnt = 1'b0;
                end
                rdy = (cyc % 4 != 3);
                if (beat_valid && rdy) begin
                    chk(beat_addr == exp_addr(ind, bwd, a, beats), ind ? "R5" : "R3",
                        "beat address", beat_addr, exp_addr(ind, bwd, a, beats));
                    beats++;
                end
                beat_ready = rdy;
            end
        end
        chk(fin, "R10", "run ended", fin, 1);
        chk(got_err == exp_err, exp_err ? "R7" : "R10", "err pulse", got_err, exp_err);
        chk(got_done == !exp_err, "R10", "done pulse", got_done, !exp_err);
        chk(beats == exp_beats, "R10", "beat count", beats, exp_beats);
        chk(fetches == exp_fetch, "R4", "fetch count", fetches, exp_fetch);
        @(negedge clk);
        chk(!busy && !done && !err, "R1", "idle after end", busy, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, fails);
        $finish;
    end

    initial begin
        int offs_f [3] = '{1, BSZ - 2, BSZ - 1};
        int offs_b [3] = '{BSZ - 2, 1, 0};
        int n0, cn;
        logic [23:0] e0;
        mem_gnt = 1'b0; beat_ready = 1'b0; mem_rdata = '0;
        for (int i = 0; i < 8; i++) lmem[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !mem_req && !beat_valid && !done && !err, "R1", "reset outputs",
            {busy, mem_req, beat_valid, done, err}, 0);
        rst_n = 1'b1;

        // R2/R3: direct mode across command kinds, wrap and block edges
        run_case("R3", 8'h01, 0, 24'hFFFFFE, 5, 0, 5, 0, 0);
        run_case("R3", 8'h02, 0, 24'h0007FD, 6, 0, 6, 0, 0);
        run_case("R3", 8'h03, 0, 24'h123456, 3, 0, 3, 0, 0);
        run_case("R2", 8'h04, 0, 24'h000010, 2, 0, 2, 0, 0);
        run_case("R3", 8'h0C, 0, 24'h000003, 6, 0, 6, 0, 0);
        run_case("R2", 8'h08, 0, 24'h000010, 4, 1, 0, 0, 0);
        run_case("R2", 8'h00, 1, LBASE, 4, 1, 0, 0, 0);
        // R12: start while busy ignored
        run_case("R12", 8'h01, 0, 24'h000100, 20, 0, 20, 0, 1);
        // R10: zero count
        run_case("R10", 8'h02, 1, LBASE, 0, 0, 0, 0, 0);

        // R5/R6/R10: forward list sweep
        for (int o = 0; o < 3; o++) begin
            e0 = 24'h003000 + 24'(offs_f[o]);
            n0 = first_run(0, e0);
            for (int c = 0; c < 4; c++) begin
                cn = (c == 0) ? 1 : (c == 1) ? n0 : (c == 2) ? n0 + 1 : n0 + BSZ + 1;
                setup_list({8'h0, e0}, 0);
                run_case("R6", (c % 2) ? 8'h01 : 8'h02, 1, LBASE, cn, 0, cn,
                         fetches_for(0, e0, cn), 0);
            end
        end
        // R5/R6/R10: backward list sweep
        for (int o = 0; o < 3; o++) begin
            e0 = 24'h003000 + 24'(offs_b[o]);
            n0 = first_run(1, e0);
            for (int c = 0; c < 4; c++) begin
                cn = (c == 0) ? 1 : (c == 1) ? n0 : (c == 2) ? n0 + 1 : n0 + BSZ + 1;
                setup_list({8'h0, e0}, 1);
                run_case("R6", 8'h0C, 1, LBASE, cn, 0, cn, fetches_for(1, e0, cn), 0);
            end
        end

        // R7: forward follow-on word off block start
        setup_list(32'h0000_47FE, 0);
        lmem[1] = 32'h0001_0001;
        run_case("R7", 8'h02, 1, LBASE, 10, 1, 2, 2, 0);
        // R7: backward follow-on word not at block end
        setup_list(32'h0000_4001, 1);
        lmem[1] = 32'h0001_0000;
        run_case("R7", 8'h0C, 1, LBASE, 10, 1, 2, 2, 0);
        // R8: nonzero pad byte in first word
        setup_list(32'h0100_4000, 0);
        run_case("R8", 8'h01, 1, LBASE, 10, 1, 0, 1, 0);
        // R8: nonzero pad byte in a later word
        setup_list(32'h0000_47FF, 0);
        lmem[1] = 32'h8001_0800;
        run_case("R8", 8'h01, 1, LBASE, 10, 1, 1, 2, 0);
        // R9: misaligned list address
        setup_list(32'h0000_4000, 0);
        run_case("R9", 8'h02, 1, LBASE + 24'd2, 10, 1, 0, 0, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, fails);
        $finish;
    end
endmodule